// File: doc/BRIEF.md
# Two-Way Intersection Light Sequencer

This block sequences the lamps of a crossing where a north-south road meets an east-west road. It steps through four phases in a fixed loop: north-south green, north-south amber, east-west green, east-west amber, and then back to north-south green. Each green phase is closed by a long "main" timer. Each amber phase is closed by a short "amber" timer. The phase register drives six registered lamp outputs.

The whole block runs on one fast system clock. Time is measured in seconds by a one-cycle enable pulse, `tick_i`, that an external divider raises once per second. Two down-the-line counters count these pulses. Both counters restart from zero whenever the phase changes, so every phase lasts its full length from the moment it is entered. An expiry from a timer that the current phase does not use has no effect. A synchronous reset returns the block to north-south green and clears both counters.

Top module: `xing_phase_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, `lamps_o` becomes 6'b001100 after that edge. Both timers restart, so the first phase after reset lasts the full MAIN_SECS ticks.
- R2: `lamps_o` bit 5/4/3 are north-south red/amber/green and bit 2/1/0 are east-west red/amber/green. The four phase codes are 001100 (NS green), 010100 (NS amber), 100001 (EW green) and 100010 (EW amber). No other value ever appears.
- R3: North-south green holds for MAIN_SECS-1 ticks (default 10). On the MAIN_SECS-th tick it moves to north-south amber.
- R4: North-south amber holds for AMBER_SECS-1 ticks (default 4). On the AMBER_SECS-th tick it moves to east-west green.
- R5: East-west green lasts MAIN_SECS ticks and then moves to east-west amber.
- R6: East-west amber lasts AMBER_SECS ticks and then moves back to north-south green.
- R7: In any cycle where `tick_i` is low, `lamps_o` does not change on the following edge.
- R8: Both timers restart at every phase entry. A phase is never shortened by ticks counted in an earlier phase.
- R9: The amber timer expires during a green phase, at the AMBER_SECS-th tick of that phase. This expiry is ignored: the lamps stay at green.
- R10: In every cycle, exactly one lamp per direction is lit, and at least one direction shows red.
- R11: `lamps_o` is registered. It takes the new phase code on the same clock edge that samples the phase-ending tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| lamps_o | output | 6 | Registered lamps {NS red, NS amber, NS green, EW red, EW amber, EW green} |

## Verification
Two cases are hard to reach from the ports, because both only show when the lamps fail to change at the right time.

- **Phase shortened by carried-over counts.** The amber counter keeps running through a green phase. If it were not cleared on phase entry, north-south amber would end after only two ticks. The stimulus reaches this case by running a complete green phase right before the amber phase and counting every tick of the amber phase.
- **Reset that fails to clear the timers.** A reset is applied part way through east-west green, with counts still pending. The bench then requires the full ten ticks of north-south green before amber appears.

The tick spacing is also varied between sparse pulses and back-to-back pulses. This shows that phase length depends only on the number of ticks, not on the cycles between them.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [1:0] {
    PH_NS_GO    = 2'd0,
    PH_NS_AMBER = 2'd1,
    PH_EW_GO    = 2'd2,
    PH_EW_AMBER = 2'd3
  } phase_e;

  // lamp bit order: {ns_red, ns_amber, ns_green, ew_red, ew_amber, ew_green}
  localparam logic [5:0] LAMP_NS_GO    = 6'b001_100;
  localparam logic [5:0] LAMP_NS_AMBER = 6'b010_100;
  localparam logic [5:0] LAMP_EW_GO    = 6'b100_001;
  localparam logic [5:0] LAMP_EW_AMBER = 6'b100_010;

  function automatic logic [5:0] lamp_code(phase_e p);
    case (p)
      PH_NS_GO:    return LAMP_NS_GO;
      PH_NS_AMBER: return LAMP_NS_AMBER;
      PH_EW_GO:    return LAMP_EW_GO;
      default:     return LAMP_EW_AMBER;
    endcase
  endfunction

endpackage

// File: rtl/phase_timer.sv
// Counts second ticks since the last clear.
// expire_o pulses on the tick that completes TERM seconds.
module phase_timer #(
  parameter int TERM = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int W = (TERM > 1) ? $clog2(TERM) : 1;

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last  = (cnt_q == W'(TERM - 1));
  assign expire_o = tick_i & at_last;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phase_fsm.sv
// Four-phase loop; each phase listens to exactly one timer.
module phase_fsm
  import xing_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   main_exp_i,
  input  logic   amber_exp_i,
  output phase_e phase_nxt_o,
  output logic   change_o
);
  phase_e cur_q;

  always_comb begin
    phase_nxt_o = cur_q;
    case (cur_q)
      PH_NS_GO:    if (main_exp_i)  phase_nxt_o = PH_NS_AMBER;
      PH_NS_AMBER: if (amber_exp_i) phase_nxt_o = PH_EW_GO;
      PH_EW_GO:    if (main_exp_i)  phase_nxt_o = PH_EW_AMBER;
      default:     if (amber_exp_i) phase_nxt_o = PH_NS_GO;
    endcase
  end

  assign change_o = (phase_nxt_o != cur_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) cur_q <= PH_NS_GO;
    else       cur_q <= phase_nxt_o;
  end
endmodule

// File: rtl/lamp_reg.sv
// Registered lamp decode, loaded from the next phase so lamps track the state register.
module lamp_reg
  import xing_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  phase_e     phase_nxt_i,
  output logic [5:0] lamps_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) lamps_o <= lamp_code(PH_NS_GO);
    else       lamps_o <= lamp_code(phase_nxt_i);
  end
endmodule

// File: rtl/xing_phase_ctrl.sv
module xing_phase_ctrl
  import xing_pkg::*;
#(
  parameter int MAIN_SECS  = 10,
  parameter int AMBER_SECS = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  output logic [5:0] lamps_o
);
  localparam int N_TMR = 2;  // index 0: main timer, index 1: amber timer

  logic [N_TMR-1:0] exp_w;
  logic             phase_chg;
  phase_e           phase_nxt;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int TERM = (g == 0) ? MAIN_SECS : AMBER_SECS;
    phase_timer #(.TERM(TERM)) u_tmr (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (phase_chg),
      .tick_i   (tick_i),
      .expire_o (exp_w[g])
    );
  end

  phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .main_exp_i  (exp_w[0]),
    .amber_exp_i (exp_w[1]),
    .phase_nxt_o (phase_nxt),
    .change_o    (phase_chg)
  );

  lamp_reg u_lamp (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_nxt_i (phase_nxt),
    .lamps_o     (lamps_o)
  );
endmodule

// File: rtl/xing_phase_ctrl_chk.sv
module xing_phase_ctrl_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       tick_i,
  input logic [5:0] lamps_o
);
  // R10: one lamp per direction
  a_r10_one_per_dir: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(lamps_o[5:3]) == 1) && ($countones(lamps_o[2:0]) == 1));

  // R10: never both directions non-red
  a_r10_one_red: assert property (@(posedge clk_i) disable iff (rst_i)
    lamps_o[5] || lamps_o[2]);

  // R7: no tick, no change
  a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(lamps_o));

  // R11: a lamp change outside reset follows a sampled tick
  a_r11_change_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(lamps_o)) |-> $past(tick_i));

  // R2: changes only along the legal phase loop
  a_r2_legal_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(lamps_o)) |->
      (($past(lamps_o) == 6'b001100) && (lamps_o == 6'b010100)) ||
      (($past(lamps_o) == 6'b010100) && (lamps_o == 6'b100001)) ||
      (($past(lamps_o) == 6'b100001) && (lamps_o == 6'b100010)) ||
      (($past(lamps_o) == 6'b100010) && (lamps_o == 6'b001100)));
endmodule

bind xing_phase_ctrl xing_phase_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .tick_i  (tick_i),
  .lamps_o (lamps_o)
);

// File: tb/xing_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module xing_phase_ctrl_tb_top;
  localparam int MAIN  = 10;
  localparam int AMBER = 4;
  localparam logic [5:0] NSG = 6'b001100, NSA = 6'b010100,
                         EWG = 6'b100001, EWA = 6'b100010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] lamps;
  int total = 0;
  int bad = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  xing_phase_ctrl #(.MAIN_SECS(MAIN), .AMBER_SECS(AMBER)) dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .lamps_o(lamps));

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lamps=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_inv(input logic [5:0] act);
    total++;
    if (!($countones(act[5:3]) == 1 && $countones(act[2:0]) == 1 && (act[5] || act[2]))) begin
      bad++;
      $display("FAIL R10: lamps=%b expected one lamp per direction with a red", act);
    end
  endtask

  // driver: one tick pulse, expected lamp value pushed to the scoreboard
  task automatic send_tick(input logic [5:0] exp, input string tag, input int gap);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor: compare right after each edge that samples a tick
  initial begin
    forever begin
      @(posedge clk);
      if (tick === 1'b1 && exp_q.size() > 0) begin
        #1;
        check(lamps, exp_q.pop_front(), tag_q.pop_front());
        check_inv(lamps);
      end
    end
  end

  // full loop; phase lengths counted in ticks
  task automatic run_loop(input int gap);
    for (int i = 1; i <= MAIN; i++)
      send_tick((i < MAIN) ? NSG : NSA, (i == AMBER) ? "R9 amber expiry ignored" : "R3 R11", gap);
    for (int i = 1; i <= AMBER; i++)
      send_tick((i < AMBER) ? NSA : EWG, "R4 R8", gap);
    for (int i = 1; i <= MAIN; i++)
      send_tick((i < MAIN) ? EWG : EWA, "R5", gap);
    for (int i = 1; i <= AMBER; i++)
      send_tick((i < AMBER) ? EWA : NSG, "R6 R2", gap);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(lamps, NSG, "R1 reset state");
    check_inv(lamps);
    repeat (20) @(negedge clk);
    check(lamps, NSG, "R7 idle hold");

    run_loop(3);   // sparse ticks
    run_loop(0);   // back-to-back ticks

    // reset mid east-west green, then full green phase required
    for (int i = 1; i <= MAIN; i++) send_tick((i < MAIN) ? NSG : NSA, "R3", 1);
    for (int i = 1; i <= AMBER; i++) send_tick((i < AMBER) ? NSA : EWG, "R4", 1);
    for (int i = 1; i <= 5; i++) send_tick(EWG, "R5", 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(lamps, NSG, "R1 reset mid-phase");
    for (int i = 1; i <= MAIN; i++)
      send_tick((i < MAIN) ? NSG : NSA, "R1 timers cleared by reset", 2);
    repeat (10) @(negedge clk);
    check(lamps, NSA, "R7 idle hold in amber");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule